// File: doc/BRIEF.md
# Boot Configuration Word Loader

This block runs once after every reset. It reads a single 16-bit configuration halfword from external boot memory and decides whether the word is programmed by checking a magic identifier in its low byte. If the identifier matches, the block latches the instruction-encoding mode, the boot identifier and the final bus width, and it arms up to two watchdog counters. It then reports completion to the boot core. If the identifier does not match, the block reports an invalid load and leaves everything disarmed.

The memory port has two channels. The read request is a valid/ready channel: the block raises `rd_req_valid` with a fixed boot address and holds it, with the address stable, until the memory accepts it with `rd_req_ready`. The memory may stall this channel for any number of cycles. The read response is a second valid/ready channel: the block raises `rd_rsp_ready` only after its request has been accepted, and it takes exactly one beat. The memory may hold back `rd_rsp_valid` for as long as it needs. Beats offered at any other time are not consumed.

The core watchdog counts on `sys_clk`. The software watchdog counts on the crystal clock `xtal_clk`, and its enable and reset are resynchronized into that domain. The reset-default periods are 327680 system cycles and 392400 crystal cycles. Each watchdog restarts its count when its own service strobe is applied.

Top module: `bootcfg_loader`

## Requirements
- R1: While reset is applied and on the first cycle after it, `bus_half`=1, and `cfg_done`, `cfg_valid`, `cfg_invalid`, `enc_var_len`, `boot_id`, `rd_rsp_ready`, `cwd_expire` and `swd_expire` are all 0.
- R2: After reset the block issues exactly one read request, with `rd_addr`=BOOT_ADDR. `rd_req_valid` is held until a cycle in which `rd_req_ready` is 1. `rd_rsp_ready` is 1 only after that acceptance and until one response beat has been taken.
- R3: When the response low byte [7:0] equals 0x5A, `cfg_done` and `cfg_valid` rise on the second `sys_clk` edge after the response handshake edge. At the same edge, `enc_var_len` takes data bit 8 and `boot_id` takes bits [7:0].
- R4: Data bits [15:12] are reserved and have no effect on any output.
- R5: `bus_half` stays 1 until configuration completes. After a valid load it equals data bit 9 (1 = 16-bit port, 0 = 32-bit port), changing together with `cfg_done`.
- R6: When bits [7:0] are not 0x5A, `cfg_done` and `cfg_invalid` rise on the first edge after the response handshake. `cfg_valid` and `enc_var_len` stay 0, `bus_half` stays 1, and neither watchdog ever pulses.
- R7: Once `cfg_done` is 1, every configuration output holds its value until the next reset, even when further response beats are offered.
- R8: With data bit 10 set on a valid load, `cwd_expire` is a one-cycle pulse. The first pulse comes CWD_PERIOD `sys_clk` cycles after `cfg_done` rises, and later pulses repeat every CWD_PERIOD cycles.
- R9: A one-cycle `cwd_kick` or `swd_kick` restarts its own watchdog count. Servicing more often than the period suppresses all pulses, and pulses resume once servicing stops.
- R10: With data bit 11 set on a valid load, `swd_expire` is a one-`xtal_clk`-cycle pulse that repeats every SWD_PERIOD crystal cycles.
- R11: A watchdog whose enable bit (10 for the core watchdog, 11 for the software watchdog) is 0 never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, sequencer and core watchdog |
| xtal_clk | input | 1 | Crystal clock, software watchdog |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts read request |
| rd_addr | output | ADDR_W | Read address, fixed to BOOT_ADDR |
| rd_rsp_valid | input | 1 | Read data beat valid |
| rd_rsp_ready | output | 1 | Block will take a read data beat |
| rd_rsp_data | input | 16 | Configuration halfword |
| bus_half | output | 1 | 1 = 16-bit memory port, 0 = 32-bit |
| enc_var_len | output | 1 | 1 = variable-length instruction encoding |
| boot_id | output | 8 | Latched boot identifier |
| cfg_done | output | 1 | Load finished, valid or not |
| cfg_valid | output | 1 | Load finished with a programmed word |
| cfg_invalid | output | 1 | Load finished with an unprogrammed word |
| cwd_kick | input | 1 | Core watchdog service strobe (sys_clk) |
| cwd_expire | output | 1 | Core watchdog timeout pulse (sys_clk) |
| swd_kick | input | 1 | Software watchdog service strobe (xtal_clk) |
| swd_expire | output | 1 | Software watchdog timeout pulse (xtal_clk) |

## Verification
Counting from the `sys_clk` edge that completes the response handshake, the invalid verdict is due one edge later, and the valid configuration two edges later with `bus_half` still 1 after the first of those edges. The bench drives the memory at falling edges and samples at the following falling edges, so every sample lands in the exact cycle of the due edge, and the cycle before it is also checked. Watchdog periods are measured as falling-edge counts in each watchdog's own clock, from `cfg_done` to the first pulse and from one pulse to the next. The software watchdog's first pulse is not timed, because its enable crosses clock domains. All configuration sweeps run with small period overrides.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;

  localparam int WORD_W   = 16;
  localparam int ID_W     = 8;
  localparam int ID_LSB   = 0;
  localparam int ENC_BIT  = 8;
  localparam int HALF_BIT = 9;
  localparam int CWD_BIT  = 10;
  localparam int SWD_BIT  = 11;
  localparam int USED_W   = SWD_BIT + 1;

  localparam logic [ID_W-1:0] BOOT_MAGIC = 8'h5A;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_FETCH  = 3'd1,
    ST_CHECK  = 3'd2,
    ST_CONFIG = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic            swd_en;
    logic            cwd_en;
    logic            half;
    logic            enc;
    logic [ID_W-1:0] id;
  } boot_cfg_t;

  function automatic boot_cfg_t decode_word(input logic [USED_W-1:0] w);
    boot_cfg_t c;
    c.swd_en = w[SWD_BIT];
    c.cwd_en = w[CWD_BIT];
    c.half   = w[HALF_BIT];
    c.enc    = w[ENC_BIT];
    c.id     = w[ID_LSB +: ID_W];
    return c;
  endfunction

  function automatic logic is_programmed(input logic [USED_W-1:0] w);
    return w[ID_LSB +: ID_W] == BOOT_MAGIC;
  endfunction

endpackage

// File: rtl/bootcfg_sync.sv
module bootcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bootcfg_wdog.sv
module bootcfg_wdog #(
  parameter int PERIOD = 327680
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic kick,
  output logic expire
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else if (!en || kick) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q    <= '0;
      expire_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      expire_q <= 1'b0;
    end
  end

  assign expire = expire_q;
endmodule

// File: rtl/bootcfg_seq.sv
module bootcfg_seq
  import bootcfg_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BOOT_ADDR = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output boot_cfg_t         cfg,
  output logic              bus_half,
  output logic              cfg_done,
  output logic              cfg_valid,
  output logic              cfg_invalid
);
  seq_state_e        state_q;
  logic              req_sent_q;
  logic [USED_W-1:0] word_q;
  boot_cfg_t         cfg_q;
  logic              half_q, done_q, valid_q, invalid_q;
  logic              rsp_take;

  // reserved bits of the halfword are never decoded
  logic unused_rsv;
  assign unused_rsv = &{1'b0, rd_rsp_data[WORD_W-1:USED_W]};

  assign rd_addr      = ADDR_W'(BOOT_ADDR);
  assign rd_req_valid = (state_q == ST_FETCH) && !req_sent_q;
  assign rd_rsp_ready = (state_q == ST_FETCH) && req_sent_q;
  assign rsp_take     = rd_rsp_ready && rd_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RESET;
      req_sent_q <= 1'b0;
      word_q     <= '0;
      cfg_q      <= '0;
      half_q     <= 1'b1;
      done_q     <= 1'b0;
      valid_q    <= 1'b0;
      invalid_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RESET: begin
          half_q     <= 1'b1;
          req_sent_q <= 1'b0;
          state_q    <= ST_FETCH;
        end
        ST_FETCH: begin
          if (rd_req_valid && rd_req_ready) req_sent_q <= 1'b1;
          if (rsp_take) begin
            word_q  <= rd_rsp_data[USED_W-1:0];
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (is_programmed(word_q)) begin
            state_q <= ST_CONFIG;
          end else begin
            done_q    <= 1'b1;
            invalid_q <= 1'b1;
            state_q   <= ST_RUN;
          end
        end
        ST_CONFIG: begin
          cfg_q   <= decode_word(word_q);
          half_q  <= decode_word(word_q).half;
          done_q  <= 1'b1;
          valid_q <= 1'b1;
          state_q <= ST_RUN;
        end
        ST_RUN: state_q <= ST_RUN;
        default: state_q <= ST_RESET;
      endcase
    end
  end

  assign cfg         = cfg_q;
  assign bus_half    = half_q;
  assign cfg_done    = done_q;
  assign cfg_valid   = valid_q;
  assign cfg_invalid = invalid_q;
endmodule

// File: rtl/bootcfg_loader.sv
module bootcfg_loader
  import bootcfg_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] BOOT_ADDR   = 32'h0000_0000,
  parameter int          CWD_PERIOD  = 327680,
  parameter int          SWD_PERIOD  = 392400,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              xtal_clk,
  input  logic              rst_n,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [15:0]       rd_rsp_data,
  output logic              bus_half,
  output logic              enc_var_len,
  output logic [7:0]        boot_id,
  output logic              cfg_done,
  output logic              cfg_valid,
  output logic              cfg_invalid,
  input  logic              cwd_kick,
  output logic              cwd_expire,
  input  logic              swd_kick,
  output logic              swd_expire
);
  boot_cfg_t cfg;
  logic      xtal_rst_n;
  logic      swd_en_x;

  bootcfg_seq #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR)) u_seq (
    .clk          (sys_clk),
    .rst_n        (rst_n),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_addr      (rd_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .rd_rsp_data  (rd_rsp_data),
    .cfg          (cfg),
    .bus_half     (bus_half),
    .cfg_done     (cfg_done),
    .cfg_valid    (cfg_valid),
    .cfg_invalid  (cfg_invalid)
  );

  assign enc_var_len = cfg.enc;
  assign boot_id     = cfg.id;

  bootcfg_wdog #(.PERIOD(CWD_PERIOD)) u_cwd (
    .clk    (sys_clk),
    .rst_n  (rst_n),
    .en     (cfg.cwd_en),
    .kick   (cwd_kick),
    .expire (cwd_expire)
  );

  bootcfg_sync #(.STAGES(SYNC_STAGES)) u_xrst (
    .clk   (xtal_clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (xtal_rst_n)
  );

  bootcfg_sync #(.STAGES(SYNC_STAGES)) u_xen (
    .clk   (xtal_clk),
    .rst_n (xtal_rst_n),
    .d     (cfg.swd_en),
    .q     (swd_en_x)
  );

  bootcfg_wdog #(.PERIOD(SWD_PERIOD)) u_swd (
    .clk    (xtal_clk),
    .rst_n  (xtal_rst_n),
    .en     (swd_en_x),
    .kick   (swd_kick),
    .expire (swd_expire)
  );
endmodule

// File: rtl/bootcfg_loader_chk.sv
module bootcfg_loader_chk (
  input logic       sys_clk,
  input logic       xtal_clk,
  input logic       rst_n,
  input logic       rd_req_valid,
  input logic       rd_req_ready,
  input logic       rd_rsp_ready,
  input logic       bus_half,
  input logic       enc_var_len,
  input logic [7:0] boot_id,
  input logic       cfg_done,
  input logic       cfg_valid,
  input logic       cfg_invalid,
  input logic       cwd_expire,
  input logic       swd_expire
);
  AST_REQ_HELD: assert property (@(posedge sys_clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid); // R2

  AST_RSP_AFTER_REQ: assert property (@(posedge sys_clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid); // R2

  AST_NO_SECOND_REQ: assert property (@(posedge sys_clk) disable iff (!rst_n)
    rd_rsp_ready |=> !rd_req_valid); // R2

  AST_HALF_UNTIL_DONE: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !cfg_done |-> bus_half); // R5

  AST_ONE_VERDICT: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cfg_done |-> $countones({cfg_valid, cfg_invalid}) == 1); // R3

  AST_INVALID_QUIET: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cfg_invalid |-> bus_half && !enc_var_len && !cwd_expire); // R6

  AST_CFG_HELD: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cfg_done |=> cfg_done && $stable(cfg_valid) && $stable(cfg_invalid)
                 && $stable(bus_half) && $stable(enc_var_len) && $stable(boot_id)); // R7

  AST_CWD_PULSE: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cwd_expire |=> !cwd_expire); // R8

  AST_CWD_NEEDS_VALID: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cwd_expire |-> cfg_valid); // R11

  AST_SWD_PULSE: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    swd_expire |=> !swd_expire); // R10

  AST_SWD_NEEDS_VALID: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    swd_expire |-> cfg_valid); // R11
endmodule

bind bootcfg_loader bootcfg_loader_chk u_chk (.*);

// File: tb/bootcfg_loader_test.sv
module bootcfg_loader_test;
  localparam int          ADDR_W = 32;
  localparam logic [31:0] BADDR  = 32'h0000_1000;
  localparam int          CWD_P  = 24;
  localparam int          SWD_P  = 20;
  localparam int          LIMIT  = 150000;

  logic sys_clk = 1'b0;
  logic xtal_clk = 1'b0;
  always #10 sys_clk = ~sys_clk;
  always #15 xtal_clk = ~xtal_clk;

  logic              rst_n = 1'b0;
  logic              rd_req_valid, rd_req_ready = 1'b0;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [15:0]       rd_rsp_data = '0;
  logic              bus_half, enc_var_len, cfg_done, cfg_valid, cfg_invalid;
  logic [7:0]        boot_id;
  logic              cwd_kick = 1'b0, cwd_expire, swd_kick = 1'b0, swd_expire;

  bootcfg_loader #(
    .ADDR_W(ADDR_W), .BOOT_ADDR(BADDR), .CWD_PERIOD(CWD_P), .SWD_PERIOD(SWD_P)
  ) uut (.*);

  int  n_chk = 0, n_err = 0, cyc = 0;
  int  cexp = 0, xexp = 0, kc = 0, xkc = 0;
  bit  kick_on = 1'b0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge sys_clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      n_chk++; n_err++;
      $display("FAIL timeout: run did not finish actual=%0d expected<%0d", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  always @(negedge sys_clk) begin
    if (cwd_expire) cexp++;
    if (kick_on) begin kc++; cwd_kick = (kc % (CWD_P/2) == 0); end
    else begin kc = 0; cwd_kick = 1'b0; end
  end

  always @(negedge xtal_clk) begin
    if (swd_expire) xexp++;
    if (kick_on) begin xkc++; swd_kick = (xkc % (SWD_P/2) == 0); end
    else begin xkc = 0; swd_kick = 1'b0; end
  end

  // one full boot; quick=1 returns right at the sample where cfg_done is due
  task automatic do_boot(input logic [15:0] w, input int rl, input int sl, input bit quick);
    bit good;
    good = (w[7:0] == 8'h5A);
    rst_n = 1'b0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0;
    repeat (2) @(negedge sys_clk);
    chk("R1", "reset bus_half", bus_half, 1);
    chk("R1", "reset done/valid/invalid", {cfg_done, cfg_valid, cfg_invalid}, 0);
    chk("R1", "reset enc/id/expire", {enc_var_len, boot_id, cwd_expire, swd_expire, rd_rsp_ready}, 0);
    rst_n = 1'b1;
    @(negedge sys_clk);
    chk("R1", "first cycle done", cfg_done, 0);
    while (!rd_req_valid) @(negedge sys_clk);
    chk("R2", "address", rd_addr, BADDR);
    repeat (rl) @(negedge sys_clk);
    chk("R2", "request held under stall", rd_req_valid, 1);
    chk("R2", "no response ready before accept", rd_rsp_ready, 0);
    rd_req_ready = 1'b1;
    @(negedge sys_clk);
    rd_req_ready = 1'b0;
    chk("R2", "single request", rd_req_valid, 0);
    repeat (sl) @(negedge sys_clk);
    chk("R2", "response ready after accept", rd_rsp_ready, 1);
    rd_rsp_valid = 1'b1; rd_rsp_data = w;
    @(negedge sys_clk);
    rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    chk("R5", "half during check", bus_half, 1);
    chk("R2", "one beat taken", rd_rsp_ready, 0);
    @(negedge sys_clk);
    if (good) begin
      chk("R3", "done not early", cfg_done, 0);
      chk("R5", "half before configure", bus_half, 1);
      @(negedge sys_clk);
      chk("R3", "done/valid/invalid", {cfg_done, cfg_valid, cfg_invalid}, 3'b110);
      chk("R3", "encoding mode", enc_var_len, w[8]);
      chk("R4", "boot id ignores reserved", boot_id, w[7:0]);
      chk("R5", "port width", bus_half, w[9]);
    end else begin
      chk("R6", "done/valid/invalid", {cfg_done, cfg_valid, cfg_invalid}, 3'b101);
      chk("R6", "half and encoding", {bus_half, enc_var_len}, 2'b10);
    end
    if (!quick) begin
      rd_rsp_valid = 1'b1; rd_rsp_data = ~w;
      repeat (3) @(negedge sys_clk);
      rd_rsp_valid = 1'b0;
      repeat (4) @(negedge sys_clk);
      chk("R7", "outputs held", {cfg_done, cfg_valid, cfg_invalid, bus_half, enc_var_len, boot_id},
          good ? {3'b110, w[9], w[8], w[7:0]} : {3'b101, 1'b1, 1'b0, 8'h00});
    end
  endtask

  initial begin
    int c0, x0, n;
    // sweep every upper byte (reserved, enables, width, mode) with a programmed id
    for (int hi = 0; hi < 256; hi++)
      do_boot({hi[7:0], 8'h5A}, hi % 3, (hi / 3) % 4, 1'b0);

    // sweep every id with all enables set; only 0x5A may load
    for (int id = 0; id < 256; id++) begin
      do_boot({8'hFF, id[7:0]}, id % 2, id % 3, 1'b0);
      if (id != 8'h5A) begin
        c0 = cexp; x0 = xexp;
        repeat (3 * CWD_P) @(negedge sys_clk);
        chk("R6", "no watchdog pulse when invalid", (cexp - c0) + (xexp - x0), 0);
      end
    end

    // core watchdog alone: first pulse and repeat period
    do_boot({8'h04, 8'h5A}, 0, 0, 1'b1);
    x0 = xexp; n = 0;
    do begin @(negedge sys_clk); n++; end while (!cwd_expire && n < 4 * CWD_P);
    chk("R8", "first core pulse delay", n, CWD_P);
    @(negedge sys_clk);
    chk("R8", "core pulse width", cwd_expire, 0);
    n = 1;
    do begin @(negedge sys_clk); n++; end while (!cwd_expire && n < 4 * CWD_P);
    chk("R8", "core period", n, CWD_P);
    chk("R11", "software watchdog off", xexp - x0, 0);

    // software watchdog alone: repeat period in crystal cycles
    do_boot({8'h08, 8'h5A}, 1, 1, 1'b1);
    c0 = cexp; n = 0;
    do begin @(negedge xtal_clk); n++; end while (!swd_expire && n < 6 * SWD_P);
    chk("R10", "software watchdog fires", swd_expire, 1);
    @(negedge xtal_clk);
    chk("R10", "software pulse width", swd_expire, 0);
    n = 1;
    do begin @(negedge xtal_clk); n++; end while (!swd_expire && n < 4 * SWD_P);
    chk("R10", "software period", n, SWD_P);
    chk("R11", "core watchdog off", cexp - c0, 0);

    // both enabled and serviced: silent; unserviced: pulses resume
    do_boot({8'h0C, 8'h5A}, 2, 0, 1'b1);
    kick_on = 1'b1;
    c0 = cexp; x0 = xexp;
    repeat (4 * CWD_P) @(negedge sys_clk);
    chk("R9", "serviced core silent", cexp - c0, 0);
    chk("R9", "serviced software silent", xexp - x0, 0);
    kick_on = 1'b0;
    c0 = cexp; x0 = xexp;
    repeat (3 * CWD_P) @(negedge sys_clk);
    chk("R9", "core resumes", (cexp - c0) >= 2, 1);
    chk("R9", "software resumes", (xexp - x0) >= 2, 1);

    summary();
    $finish;
  end
endmodule